// File: doc/BRIEF.md
# AUX request to I2C transaction controller

This controller serves a display auxiliary channel one request at a time. Each request carries a 4-bit command, an address, a byte count from 1 to 16 and a 16-byte data buffer. Native requests become a run of single-byte accesses on a local register port covering a 20-bit byte address space. I2C requests drive a downstream I2C master through a start / byte / stop operation port. Every request ends with a one-cycle reply that carries a 2-bit reply code and the data buffer, which has been filled on reads.

Plain I2C requests always leave the downstream bus closed with a stop. Middle-of-transaction (MOT) requests can leave it open, so a burst of MOT requests shares one I2C transaction. A new start is only issued when the address or the command changes, or when the bus is closed.

Top module: `aux_i2c_xact_ctrl`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the single-cycle `reply_valid` pulse for that request has been given.
- R2: Command codes are 4'b1000 native write, 4'b1001 native read, 4'b0000 I2C write, 4'b0001 I2C read, 4'b0100 MOT write and 4'b0101 MOT read. Any other code, or a length outside 1..16, gives `reply_valid` with reply code 1 (NACK) in the cycle after acceptance, with no register or I2C operation.
- R3: A native request of length N makes N single-byte register accesses, at the address and then at each following address, wrapping modulo 2^20. A write sends `req_wdata` byte i, taken from bits 8i+7:8i. A read places each returned byte at byte i of `reply_rdata`.
- R4: A native access answered with `reg_err` stops the request at that byte with reply code 1 (NACK). If every byte succeeds, the reply code is 0 (ACK).
- R5: A plain I2C request first issues a STOP if the downstream bus is open. It then issues a START with address bits 6:0 and the read flag (command bit 0), then the bytes, and always ends with a STOP. If all bytes succeed, the reply code is ACK.
- R6: In a plain I2C request, a START or byte answered with `i2c_op_nack` sends no further bytes, still ends with a STOP, and replies NACK.
- R7: An MOT request issues a START only when the bus is closed, or when its full address or its command differs from those of the last opened MOT transaction. The last two cases are preceded by a STOP. Otherwise the bytes follow directly.
- R8: An MOT request whose bytes all succeed replies ACK and issues no STOP, so the bus stays open.
- R9: An MOT request whose START is refused replies NACK without a STOP and leaves the bus closed. A refused MOT byte sends no further bytes, is followed by a STOP, and replies NACK.
- R10: An operation stays valid with stable fields until its `*_done` input is seen. Operation codes are 0 START, 1 BYTE and 2 STOP. Register and I2C operations are never valid together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Native byte address, or I2C address in bits 6:0 |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write bytes, byte i in bits 8i+7:8i |
| reply_valid | output | 1 | One-cycle reply strobe |
| reply_code | output | 2 | 0 ACK, 1 NACK |
| reply_rdata | output | 128 | Data buffer, holding read bytes |
| reg_valid | output | 1 | Register access pending |
| reg_write | output | 1 | Access is a write |
| reg_addr | output | 20 | Byte address of the access |
| reg_wdata | output | 8 | Byte to write |
| reg_done | input | 1 | Access complete |
| reg_err | input | 1 | Access failed, valid with reg_done |
| reg_rdata | input | 8 | Byte read, valid with reg_done |
| i2c_op_valid | output | 1 | I2C operation pending |
| i2c_op | output | 2 | 0 START, 1 BYTE, 2 STOP |
| i2c_dev_addr | output | 7 | Target address for START |
| i2c_rd | output | 1 | Transfer direction is read |
| i2c_wdata | output | 8 | Byte to send on a write BYTE |
| i2c_op_done | input | 1 | Operation complete |
| i2c_op_nack | input | 1 | START or BYTE refused, valid with done |
| i2c_rdata | input | 8 | Byte received, valid with done |

## Verification
The assertions assume that `reg_done` and `i2c_op_done` are pulsed only while the matching valid is high, once per operation. They also assume that request fields are meaningful only in the accepting cycle. The bench responders meet this: they answer on the falling edge after seeing a pending operation, drop done on the next falling edge, and model the I2C target's refusals and its byte counter between starts. Requests are applied only while `req_ready` is high, and are withdrawn after one accepting edge.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;
   typedef enum logic [1:0] {K_BAD, K_NAT, K_I2C, K_MOT} req_kind_t;
   localparam logic [1:0] RC_ACK   = 2'd0;
   localparam logic [1:0] RC_NACK  = 2'd1;
   localparam logic [1:0] OP_START = 2'd0;
   localparam logic [1:0] OP_BYTE  = 2'd1;
   localparam logic [1:0] OP_STOP  = 2'd2;
   localparam int CMD_W     = 4;
   localparam int BIT_NAT   = 3;
   localparam int BIT_MOT   = 2;
   localparam int BIT_READ  = 0;
endpackage

// File: rtl/aux_cmd_classify.sv
module aux_cmd_classify
   import aux_xact_pkg::*;
#(
   parameter int MAX_LEN = 16,
   parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic [CMD_W-1:0] cmd,
   input  logic [LEN_W-1:0] len,
   output req_kind_t        kind,
   output logic             is_read
);
   logic len_ok;
   assign len_ok  = (len != '0) && (len <= LEN_W'(MAX_LEN));
   assign is_read = cmd[BIT_READ];

   always_comb begin
      kind = K_BAD;
      if (len_ok && cmd[1] == 1'b0) begin
         if (cmd[BIT_NAT]) begin
            if (!cmd[BIT_MOT]) kind = K_NAT;
         end else if (cmd[BIT_MOT]) begin
            kind = K_MOT;
         end else begin
            kind = K_I2C;
         end
      end
   end
endmodule

// File: rtl/aux_mot_track.sv
module aux_mot_track
   import aux_xact_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_open,
   input  logic              clr_open,
   input  logic              rec,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [CMD_W-1:0]  cur_cmd,
   output logic              bus_open,
   output logic              restart
);
   logic [ADDR_W-1:0] last_addr;
   logic [CMD_W-1:0]  last_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_open  <= 1'b0;
         last_addr <= '0;
         last_cmd  <= '0;
      end else begin
         if (set_open)      bus_open <= 1'b1;
         else if (clr_open) bus_open <= 1'b0;
         if (rec) begin
            last_addr <= cur_addr;
            last_cmd  <= cur_cmd;
         end
      end
   end

   assign restart = (cur_addr != last_addr) || (cur_cmd != last_cmd);

   a_r7_open_close_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_open && clr_open));
   a_r7_open_follows_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_open |=> bus_open);
endmodule

// File: rtl/aux_xfer_buf.sv
module aux_xfer_buf #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [DEPTH*DATA_W-1:0] load_data,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        idx,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [DATA_W-1:0]       rd_data,
   output logic [DEPTH*DATA_W-1:0] all_data
);
   logic [DATA_W-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  ent[g] <= '0;
         else if (load)                               ent[g] <= load_data[g*DATA_W +: DATA_W];
         else if (wr_en && idx == IDX_W'(g))          ent[g] <= wr_data;
      end
      assign all_data[g*DATA_W +: DATA_W] = ent[g];
   end

   assign rd_data = ent[idx];
endmodule

// File: rtl/aux_i2c_xact_ctrl.sv
module aux_i2c_xact_ctrl
   import aux_xact_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 8,
   parameter int MAX_LEN  = 16,
   parameter int DEV_W    = 7,
   localparam int LEN_W   = $clog2(MAX_LEN + 1),
   localparam int IDX_W   = $clog2(MAX_LEN),
   localparam int BUF_W   = MAX_LEN * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [BUF_W-1:0]  req_wdata,
   output logic              reply_valid,
   output logic [1:0]        reply_code,
   output logic [BUF_W-1:0]  reply_rdata,
   output logic              reg_valid,
   output logic              reg_write,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_done,
   input  logic              reg_err,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              i2c_op_valid,
   output logic [1:0]        i2c_op,
   output logic [DEV_W-1:0]  i2c_dev_addr,
   output logic              i2c_rd,
   output logic [DATA_W-1:0] i2c_wdata,
   input  logic              i2c_op_done,
   input  logic              i2c_op_nack,
   input  logic [DATA_W-1:0] i2c_rdata
);
   if (MAX_LEN < 2) begin : g_chk_len
      $error("MAX_LEN must be at least 2");
   end
   if (ADDR_W < DEV_W) begin : g_chk_addr
      $error("ADDR_W must cover the I2C address");
   end

   typedef enum logic [2:0] {
      ST_IDLE, ST_ROUTE, ST_NAT, ST_PRESTOP, ST_START, ST_BYTE, ST_POSTSTOP, ST_REPLY
   } state_t;

   state_t            st;
   req_kind_t         kind_in, kind_q;
   logic              rd_in, rd_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [IDX_W-1:0]  idx_q;
   logic [1:0]        code_q;
   logic              accept, last_byte, nat_fire, i2c_fire;
   logic              buf_wr, set_open, clr_open, rec, bus_open, restart;
   logic [DATA_W-1:0] buf_byte, buf_wdat;

   aux_cmd_classify #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) i_classify (
      .cmd(req_cmd), .len(req_len), .kind(kind_in), .is_read(rd_in));

   aux_mot_track #(.ADDR_W(ADDR_W)) i_track (
      .clk(clk), .rst_n(rst_n), .set_open(set_open), .clr_open(clr_open),
      .rec(rec), .cur_addr(addr_q), .cur_cmd(cmd_q),
      .bus_open(bus_open), .restart(restart));

   aux_xfer_buf #(.DEPTH(MAX_LEN), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_buf (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_data(req_wdata),
      .wr_en(buf_wr), .idx(idx_q), .wr_data(buf_wdat),
      .rd_data(buf_byte), .all_data(reply_rdata));

   assign req_ready    = (st == ST_IDLE);
   assign accept       = req_valid && req_ready;
   assign reply_valid  = (st == ST_REPLY);
   assign reply_code   = code_q;

   assign reg_valid    = (st == ST_NAT);
   assign reg_write    = !rd_q;
   assign reg_addr     = addr_q + ADDR_W'(idx_q);
   assign reg_wdata    = buf_byte;

   assign i2c_op_valid = (st == ST_PRESTOP) || (st == ST_START) ||
                         (st == ST_BYTE) || (st == ST_POSTSTOP);
   assign i2c_op       = (st == ST_START) ? OP_START :
                         (st == ST_BYTE)  ? OP_BYTE  : OP_STOP;
   assign i2c_dev_addr = addr_q[DEV_W-1:0];
   assign i2c_rd       = rd_q;
   assign i2c_wdata    = buf_byte;

   assign last_byte = (LEN_W'(idx_q) == len_q - LEN_W'(1));
   assign nat_fire  = reg_valid && reg_done;
   assign i2c_fire  = i2c_op_valid && i2c_op_done;
   assign buf_wr    = rd_q && ((nat_fire && !reg_err) ||
                               (st == ST_BYTE && i2c_fire && !i2c_op_nack));
   assign buf_wdat  = (st == ST_NAT) ? reg_rdata : i2c_rdata;
   assign set_open  = (st == ST_START) && i2c_fire && !i2c_op_nack;
   assign clr_open  = ((st == ST_PRESTOP || st == ST_POSTSTOP) && i2c_fire) ||
                      ((st == ST_START) && i2c_fire && i2c_op_nack);
   assign rec       = set_open && (kind_q == K_MOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         kind_q <= K_BAD;
         rd_q   <= 1'b0;
         cmd_q  <= '0;
         addr_q <= '0;
         len_q  <= '0;
         idx_q  <= '0;
         code_q <= RC_ACK;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               kind_q <= kind_in;
               rd_q   <= rd_in;
               cmd_q  <= req_cmd;
               addr_q <= req_addr;
               len_q  <= req_len;
               idx_q  <= '0;
               code_q <= RC_NACK;
               st     <= (kind_in == K_BAD) ? ST_REPLY : ST_ROUTE;
            end
            ST_ROUTE: begin
               case (kind_q)
                  K_NAT:   st <= ST_NAT;
                  K_I2C:   st <= bus_open ? ST_PRESTOP : ST_START;
                  default: st <= !bus_open ? ST_START :
                                 restart   ? ST_PRESTOP : ST_BYTE;
               endcase
            end
            ST_NAT: if (nat_fire) begin
               if (reg_err) begin
                  code_q <= RC_NACK;
                  st     <= ST_REPLY;
               end else if (last_byte) begin
                  code_q <= RC_ACK;
                  st     <= ST_REPLY;
               end else begin
                  idx_q  <= idx_q + IDX_W'(1);
               end
            end
            ST_PRESTOP: if (i2c_fire) st <= ST_START;
            ST_START: if (i2c_fire) begin
               if (i2c_op_nack) begin
                  code_q <= RC_NACK;
                  st     <= (kind_q == K_I2C) ? ST_POSTSTOP : ST_REPLY;
               end else begin
                  st     <= ST_BYTE;
               end
            end
            ST_BYTE: if (i2c_fire) begin
               if (i2c_op_nack) begin
                  code_q <= RC_NACK;
                  st     <= ST_POSTSTOP;
               end else if (last_byte) begin
                  code_q <= RC_ACK;
                  st     <= (kind_q == K_I2C) ? ST_POSTSTOP : ST_REPLY;
               end else begin
                  idx_q  <= idx_q + IDX_W'(1);
               end
            end
            ST_POSTSTOP: if (i2c_fire) st <= ST_REPLY;
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r1_busy_at_reply: assert property (@(posedge clk) disable iff (!rst_n)
      reply_valid |-> !req_ready);
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reply_valid |=> !reply_valid);
   a_r2_bad_fast_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind_in == K_BAD) |=>
         (reply_valid && reply_code == RC_NACK && !reg_valid && !i2c_op_valid));
   a_r3_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_done) |=> (reg_valid && $stable(reg_addr) && $stable(reg_wdata)));
   a_r5_plain_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (reply_valid && kind_q == K_I2C) |-> !bus_open);
   a_r8_mot_left_open: assert property (@(posedge clk) disable iff (!rst_n)
      (reply_valid && kind_q == K_MOT && reply_code == RC_ACK) |-> bus_open);
   a_r10_i2c_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (i2c_op_valid && !i2c_op_done) |=>
         (i2c_op_valid && $stable(i2c_op) && $stable(i2c_wdata) && $stable(i2c_dev_addr)));
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_valid && i2c_op_valid));
endmodule

// File: tb/test_aux_i2c_xact_ctrl.sv
module test_aux_i2c_xact_ctrl;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0, req_ready;
   logic [3:0]   req_cmd = '0;
   logic [19:0]  req_addr = '0;
   logic [4:0]   req_len = '0;
   logic [127:0] req_wdata = '0;
   logic         reply_valid;
   logic [1:0]   reply_code;
   logic [127:0] reply_rdata;
   logic         reg_valid, reg_write;
   logic [19:0]  reg_addr;
   logic [7:0]   reg_wdata;
   logic         reg_done = 1'b0, reg_err = 1'b0;
   logic [7:0]   reg_rdata = '0;
   logic         i2c_op_valid, i2c_rd;
   logic [1:0]   i2c_op;
   logic [6:0]   i2c_dev_addr;
   logic [7:0]   i2c_wdata;
   logic         i2c_op_done = 1'b0, i2c_op_nack = 1'b0;
   logic [7:0]   i2c_rdata = '0;

   aux_i2c_xact_ctrl i_aux_i2c_xact_ctrl (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, failures = 0;
   // responder state and logs
   logic [19:0] err_addr = 20'hFFFFF;
   logic        err_en = 1'b0;
   logic [6:0]  nack_dev = 7'h7F;
   logic [7:0]  fail_at = 8'hFF;
   logic [7:0]  bcnt = '0;
   logic [20:0] rlog_a [64];
   logic [7:0]  rlog_d [64];
   logic [17:0] ilog [64];
   int rn = 0, in = 0;
   logic [1:0]   got_code;
   logic [127:0] got_data;
   int lat;

   function automatic logic [17:0] e_start(logic rd, logic [6:0] a);
      return {2'd0, 8'h00, rd, a};
   endfunction
   function automatic logic [17:0] e_byte(logic [7:0] d);
      return {2'd1, 8'h00, d};
   endfunction
   function automatic logic [17:0] e_stop();
      return {2'd2, 16'h0};
   endfunction

   task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   initial begin : reg_resp
      forever begin
         @(negedge clk);
         if (reg_valid && !reg_done) begin
            reg_done  = 1'b1;
            reg_err   = err_en && (reg_addr == err_addr);
            reg_rdata = reg_addr[7:0] ^ 8'h5A;
            if (rn < 64) begin
               rlog_a[rn] = {reg_write, reg_addr};
               rlog_d[rn] = reg_wdata;
            end
            rn++;
         end else begin
            reg_done = 1'b0;
            reg_err  = 1'b0;
         end
      end
   end

   initial begin : i2c_resp
      forever begin
         @(negedge clk);
         if (i2c_op_valid && !i2c_op_done) begin
            i2c_op_done = 1'b1;
            i2c_op_nack = 1'b0;
            if (i2c_op == 2'd0) begin
               i2c_op_nack = (i2c_dev_addr == nack_dev);
               bcnt = '0;
               if (in < 64) ilog[in] = e_start(i2c_rd, i2c_dev_addr);
            end else if (i2c_op == 2'd1) begin
               i2c_op_nack = (bcnt == fail_at);
               i2c_rdata = 8'hC0 + bcnt;
               if (in < 64) ilog[in] = e_byte(i2c_rd ? 8'h00 : i2c_wdata);
               bcnt++;
            end else begin
               if (in < 64) ilog[in] = e_stop();
            end
            in++;
         end else begin
            i2c_op_done = 1'b0;
            i2c_op_nack = 1'b0;
         end
      end
   end

   task automatic do_req(logic [3:0] cmd, logic [19:0] addr, logic [4:0] len, logic [127:0] wd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      rn = 0; in = 0;
      req_cmd = cmd; req_addr = addr; req_len = len; req_wdata = wd;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!reply_valid && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      if (!reply_valid) begin
         failures++;
         $display("FAIL R1 no reply got=0 exp=1");
      end
      got_code = reply_code;
      got_data = reply_rdata;
   endtask

   task automatic t_reset();
      chk("R1 reset ready", req_ready, 1'b1);
      chk("R1 reset reply", reply_valid, 1'b0);
      chk("R10 reset ops", {reg_valid, i2c_op_valid}, 2'b00);
   endtask

   task automatic t_bad();
      do_req(4'b1010, 20'h10, 5'd2, '0);
      chk("R2 bad cmd code", got_code, 2'd1);
      chk("R2 bad cmd latency", lat, 1);
      chk("R2 bad cmd no activity", rn + in, 0);
      do_req(4'b1001, 20'h10, 5'd0, '0);
      chk("R2 zero len code", got_code, 2'd1);
      chk("R2 zero len no activity", rn + in, 0);
      do_req(4'b0001, 20'h10, 5'd17, '0);
      chk("R2 long len code", got_code, 2'd1);
   endtask

   task automatic t_nat_write();
      do_req(4'b1000, 20'hFFFFE, 5'd4, 128'h44_33_22_11);
      chk("R4 nat write ack", got_code, 2'd0);
      chk("R3 nat write count", rn, 4);
      for (int i = 0; i < 4; i++) begin
         chk("R3 nat write addr", rlog_a[i], {1'b1, 20'(20'hFFFFE + i)});
         chk("R3 nat write data", rlog_d[i], 8'(8'h11 * (i + 1)));
      end
   endtask

   task automatic t_nat_read();
      do_req(4'b1001, 20'h00100, 5'd3, '0);
      chk("R4 nat read ack", got_code, 2'd0);
      chk("R3 nat read count", rn, 3);
      for (int i = 0; i < 3; i++) begin
         chk("R3 nat read addr", rlog_a[i], {1'b0, 20'(20'h100 + i)});
         chk("R3 nat read data", got_data[i*8 +: 8], 8'((8'h00 + i) ^ 8'h5A));
      end
   endtask

   task automatic t_nat_err();
      err_en = 1'b1; err_addr = 20'h00202;
      do_req(4'b1001, 20'h00200, 5'd5, '0);
      err_en = 1'b0;
      chk("R4 nat err nack", got_code, 2'd1);
      chk("R4 nat err stops", rn, 3);
   endtask

   task automatic t_plain_write();
      do_req(4'b0000, 20'h50, 5'd2, 128'hBB_AA);
      chk("R5 plain wr ack", got_code, 2'd0);
      chk("R5 plain wr count", in, 4);
      chk("R5 plain wr start", ilog[0], e_start(1'b0, 7'h50));
      chk("R5 plain wr b0", ilog[1], e_byte(8'hAA));
      chk("R5 plain wr b1", ilog[2], e_byte(8'hBB));
      chk("R5 plain wr stop", ilog[3], e_stop());
   endtask

   task automatic t_mot_burst();
      do_req(4'b0101, 20'h50, 5'd2, '0);
      chk("R8 mot first ack", got_code, 2'd0);
      chk("R7 mot first count", in, 3);
      chk("R7 mot first start", ilog[0], e_start(1'b1, 7'h50));
      chk("R8 mot first data", got_data[15:0], 16'hC1C0);
      do_req(4'b0101, 20'h50, 5'd1, '0);
      chk("R7 mot same no start", in, 1);
      chk("R7 mot same byte", ilog[0], e_byte(8'h00));
      chk("R8 mot same data", got_data[7:0], 8'hC2);
      do_req(4'b0100, 20'h50, 5'd1, 128'h77);
      chk("R7 mot cmd change count", in, 3);
      chk("R7 mot cmd change stop", ilog[0], e_stop());
      chk("R7 mot cmd change start", ilog[1], e_start(1'b0, 7'h50));
      chk("R7 mot cmd change byte", ilog[2], e_byte(8'h77));
      do_req(4'b0100, 20'h51, 5'd1, 128'h66);
      chk("R7 mot addr change count", in, 3);
      chk("R7 mot addr change seq", {ilog[0], ilog[1]}, {e_stop(), e_start(1'b0, 7'h51)});
      chk("R8 mot ack", got_code, 2'd0);
   endtask

   task automatic t_plain_after_open();
      do_req(4'b0001, 20'h51, 5'd2, '0);
      chk("R5 plain open ack", got_code, 2'd0);
      chk("R5 plain open count", in, 5);
      chk("R5 plain open prestop", ilog[0], e_stop());
      chk("R5 plain open start", ilog[1], e_start(1'b1, 7'h51));
      chk("R5 plain open poststop", ilog[4], e_stop());
      chk("R5 plain open data", got_data[15:0], 16'hC1C0);
   endtask

   task automatic t_mot_byte_fail();
      fail_at = 8'd1;
      do_req(4'b0100, 20'h52, 5'd3, 128'h03_02_01);
      fail_at = 8'hFF;
      chk("R9 mot byte fail nack", got_code, 2'd1);
      chk("R9 mot byte fail count", in, 4);
      chk("R9 mot byte fail stop", ilog[3], e_stop());
   endtask

   task automatic t_mot_start_fail();
      nack_dev = 7'h33;
      do_req(4'b0100, 20'h33, 5'd1, 128'h9);
      chk("R9 mot start fail nack", got_code, 2'd1);
      chk("R9 mot start fail no stop", in, 1);
      do_req(4'b0000, 20'h34, 5'd1, 128'h9);
      chk("R9 bus closed after refusal", in, 3);
      chk("R9 bus closed first op", ilog[0], e_start(1'b0, 7'h34));
   endtask

   task automatic t_plain_fail();
      do_req(4'b0000, 20'h33, 5'd2, '0);
      chk("R6 plain start fail nack", got_code, 2'd1);
      chk("R6 plain start fail seq", {ilog[0], ilog[1]}, {e_start(1'b0, 7'h33), e_stop()});
      chk("R6 plain start fail count", in, 2);
      nack_dev = 7'h7F;
      fail_at = 8'd0;
      do_req(4'b0000, 20'h40, 5'd3, 128'h3_2_1);
      fail_at = 8'hFF;
      chk("R6 plain byte fail nack", got_code, 2'd1);
      chk("R6 plain byte fail count", in, 3);
      chk("R6 plain byte fail stop", ilog[2], e_stop());
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired got=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_bad();
      t_nat_write();
      t_nat_read();
      t_nat_err();
      t_plain_write();
      t_mot_burst();
      t_plain_after_open();
      t_mot_byte_fail();
      t_mot_start_fail();
      t_plain_fail();
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule